// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port that moves one byte at a time over a single data line while generating the shift clock itself. Its time base is an oscillator-rate enable pulse (`osc_en`). Every bit occupies twelve of those pulses. The clock is driven low for the first ten pulses of a bit and high for the last two, so the data line has a long settling window before each rising edge and a short hold after it.

A transmit frame begins when a byte is accepted on the write stream. The stream uses valid/ready rules. A byte transfers only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while the port is idle. While a frame is running, `wr_ready` is low, and an offered byte is neither taken nor remembered. The port exerts no other back-pressure, and `wr_valid` may be withdrawn at any time without harm.

A receive frame begins when software clears the receive flag while receive is enabled. Each frame has exactly eight bits, sent least significant bit first. When a frame completes, the transmit flag (`ti`) or the receive flag (`ri`) is raised, and it stays raised until its clear strobe arrives.

Top module: `sm_shift_port`

## Requirements
- R1: Inside a frame, each bit period lasts 12 `osc_en` pulses. `sclk` is low during the first 10 pulses of the period and high during the last 2.
- R2: During a transmit frame, the 8 bits of the accepted byte appear on `sd_out` in order from bit 0 to bit 7. Each bit changes only where `sclk` falls. It therefore stays stable for 10 pulses before the rising edge and for 2 pulses after it.
- R3: `wr_ready` is high exactly when no frame is running. A `wr_valid` pulse that arrives during a frame has no effect, and the frame in progress continues unchanged.
- R4: `ti` rises exactly 96 `osc_en` pulses after the accepting edge. It then stays high until `clr_ti` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R5: A receive frame starts only in an idle cycle where `clr_ri` is high and `rx_en` is 1. When `rx_en` is 0, `clr_ri` only clears `ri`. In that case `sclk` stays high and `wr_ready` stays high.
- R6: During reception, `sd_in` is sampled on the `osc_en` pulse at which `sclk` rises. The first sample becomes bit 0 of the result. At the end of the frame, `rx_data` takes the 8 sampled bits and `ri` is set. `ri` stays set until `clr_ri` is pulsed.
- R7: After reset, `ti`, `ri`, `rx_data` and `sd_oe` are 0, while `wr_ready` is 1. Whenever the port is idle, `sclk` and `sd_out` are 1 and `sd_oe` is 0.
- R8: While `osc_en` is low, a running frame is frozen: `sclk` and `sd_out` do not change.
- R9: If a write and a receive start are offered in the same idle cycle, the write wins. A transmit frame starts and `sd_oe` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate enable pulse; all frame timing counts these |
| wr_valid | input | 1 | Transmit byte offered |
| wr_ready | output | 1 | Port idle; a byte offered now is accepted |
| wr_data | input | 8 | Transmit byte |
| rx_en | input | 1 | Receive enable |
| rx_data | output | 8 | Last received byte |
| ti | output | 1 | Transmit-complete flag |
| ri | output | 1 | Receive-complete flag |
| clr_ti | input | 1 | Clear strobe for `ti` |
| clr_ri | input | 1 | Clear strobe for `ri`; also starts reception when `rx_en` is 1 |
| sd_in | input | 1 | Serial data in, while receiving |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for the data line; high only while transmitting |
| sclk | output | 1 | Shift clock; high when idle |

## Verification
An error in the tick or bit counter shows up on `sclk` within one bit period: a low phase becomes longer or shorter, or a frame ends too early or too late. The late or early `ti` or `ri` then reveals the same error at the end of the frame. An error in the shift register is not visible on `sclk`. It appears on `sd_out` at the next bit boundary during transmission, and only in `rx_data` at the end of the frame during reception. For that reason, the reference model is compared on every cycle, and each frame is checked again for its full contents and length.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    SM_IDLE = 2'd0,
    SM_TX   = 2'd1,
    SM_RX   = 2'd2
  } sm_mode_e;
endpackage

// File: rtl/sm_phase_gen.sv
// Bit timing: counts oscillator ticks inside a bit and bits inside a frame.
module sm_phase_gen #(
  parameter int BIT_TICKS  = 12,
  parameter int LOW_TICKS  = 10,
  parameter int FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic busy,
  input  logic start,
  output logic sclk,
  output logic sample_stb,
  output logic bit_wrap,
  output logic frame_end
);
  localparam int TW = $clog2(BIT_TICKS);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [TW-1:0] T_LAST = TW'(BIT_TICKS - 1);
  localparam logic [TW-1:0] T_LOW  = TW'(LOW_TICKS);
  localparam logic [TW-1:0] T_SAMP = TW'(LOW_TICKS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(FRAME_BITS - 1);

  logic [TW-1:0] tick_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      bit_q  <= '0;
    end else if (start) begin
      tick_q <= '0;
      bit_q  <= '0;
    end else if (busy && osc_en) begin
      if (tick_q == T_LAST) begin
        tick_q <= '0;
        bit_q  <= (bit_q == B_LAST) ? '0 : bit_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign sclk       = !(busy && (tick_q < T_LOW));
  assign sample_stb = busy && osc_en && (tick_q == T_SAMP);
  assign bit_wrap   = busy && osc_en && (tick_q == T_LAST);
  assign frame_end  = bit_wrap && (bit_q == B_LAST);
endmodule

// File: rtl/sm_ctrl.sv
// Mode control: frame start arbitration and completion flags.
module sm_ctrl
  import sm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_valid,
  input  logic     clr_ti,
  input  logic     clr_ri,
  input  logic     rx_en,
  input  logic     frame_end,
  output sm_mode_e mode,
  output logic     start_tx,
  output logic     start_rx,
  output logic     busy,
  output logic     ti,
  output logic     ri
);
  sm_mode_e mode_q;
  logic     ti_q, ri_q;
  logic     idle;

  assign idle     = (mode_q == SM_IDLE);
  assign start_tx = idle && wr_valid;
  assign start_rx = idle && !wr_valid && clr_ri && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SM_IDLE;
    end else if (start_tx) begin
      mode_q <= SM_TX;
    end else if (start_rx) begin
      mode_q <= SM_RX;
    end else if (frame_end) begin
      mode_q <= SM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti_q <= 1'b0;
      ri_q <= 1'b0;
    end else begin
      if (frame_end && mode_q == SM_TX) ti_q <= 1'b1;
      else if (clr_ti)                  ti_q <= 1'b0;
      if (frame_end && mode_q == SM_RX) ri_q <= 1'b1;
      else if (clr_ri)                  ri_q <= 1'b0;
    end
  end

  assign mode = mode_q;
  assign busy = !idle;
  assign ti   = ti_q;
  assign ri   = ri_q;
endmodule

// File: rtl/sm_shifter.sv
// Shared shift register for both directions plus the receive buffer.
module sm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift_tx,
  input  logic         sample,
  input  logic         sd_in,
  input  logic         commit,
  input  logic         tx_active,
  output logic         sd_out,
  output logic [W-1:0] rx_data
);
  logic [W-1:0] sh_q;
  logic [W-1:0] rxb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (load) begin
      sh_q <= din;
    end else if (shift_tx) begin
      sh_q <= {1'b1, sh_q[W-1:1]};
    end else if (sample) begin
      sh_q <= {sd_in, sh_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxb_q <= '0;
    else if (commit) rxb_q <= sh_q;
  end

  assign sd_out  = tx_active ? sh_q[0] : 1'b1;
  assign rx_data = rxb_q;
endmodule

// File: rtl/sm_shift_port.sv
module sm_shift_port
  import sm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BIT_TICKS = 12,
  parameter int LOW_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              ti,
  output logic              ri,
  input  logic              clr_ti,
  input  logic              clr_ri,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              sclk
);
  sm_mode_e mode;
  logic start_tx, start_rx, busy;
  logic sample_stb, bit_wrap, frame_end;
  logic tx_active, rx_active;

  sm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .clr_ti   (clr_ti),
    .clr_ri   (clr_ri),
    .rx_en    (rx_en),
    .frame_end(frame_end),
    .mode     (mode),
    .start_tx (start_tx),
    .start_rx (start_rx),
    .busy     (busy),
    .ti       (ti),
    .ri       (ri)
  );

  sm_phase_gen #(
    .BIT_TICKS (BIT_TICKS),
    .LOW_TICKS (LOW_TICKS),
    .FRAME_BITS(DATA_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .busy      (busy),
    .start     (start_tx || start_rx),
    .sclk      (sclk),
    .sample_stb(sample_stb),
    .bit_wrap  (bit_wrap),
    .frame_end (frame_end)
  );

  assign tx_active = (mode == SM_TX);
  assign rx_active = (mode == SM_RX);

  sm_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_tx),
    .din      (wr_data),
    .shift_tx (bit_wrap && !frame_end && tx_active),
    .sample   (sample_stb && rx_active),
    .sd_in    (sd_in),
    .commit   (frame_end && rx_active),
    .tx_active(tx_active),
    .sd_out   (sd_out),
    .rx_data  (rx_data)
  );

  assign wr_ready = !busy;
  assign sd_oe    = tx_active;
endmodule

// File: rtl/sm_shift_port_chk.sv
module sm_shift_port_chk #(
  parameter int DATA_W    = 8,
  parameter int LOW_TICKS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_en,
  input logic              wr_ready,
  input logic              sclk,
  input logic              sd_out,
  input logic              sd_oe,
  input logic              ti,
  input logic              ri,
  input logic              clr_ti,
  input logic              clr_ri,
  input logic [DATA_W-1:0] rx_data
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (sclk)   low_cnt <= '0;
    else if (osc_en) low_cnt <= low_cnt + 1'b1;
  end

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> (int'(low_cnt) < LOW_TICKS)); // R1
  AST_RISE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sd_out)); // R2
  AST_BUSY_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !wr_ready); // R3
  AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !clr_ti) |=> ti); // R4
  AST_TI_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> wr_ready); // R4
  AST_RI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !clr_ri) |=> ri); // R6
  AST_RXDATA_WITH_RI: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $rose(ri)); // R6
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (sclk && sd_out && !sd_oe)); // R7
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !wr_ready) |=> ($stable(sclk) && $stable(sd_out))); // R8
endmodule

bind sm_shift_port sm_shift_port_chk #(
  .DATA_W   (DATA_W),
  .LOW_TICKS(LOW_TICKS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .osc_en  (osc_en),
  .wr_ready(wr_ready),
  .sclk    (sclk),
  .sd_out  (sd_out),
  .sd_oe   (sd_oe),
  .ti      (ti),
  .ri      (ri),
  .clr_ti  (clr_ti),
  .clr_ri  (clr_ri),
  .rx_data (rx_data)
);

// File: tb/sim_sm_shift_port.sv
`timescale 1ns/1ps
module sim_sm_shift_port;
  localparam int NB = 8;
  localparam int BT = 12;
  localparam int LT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic rx_en = 1'b0;
  logic clr_ti = 1'b0;
  logic clr_ri = 1'b0;
  logic sd_in = 1'b1;
  logic wr_ready, ti, ri, sd_out, sd_oe, sclk;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  sm_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rx_en(rx_en), .rx_data(rx_data), .ti(ti), .ri(ri),
    .clr_ti(clr_ti), .clr_ri(clr_ri),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .sclk(sclk)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int div = 1;
  int ocnt = 0;
  logic [7:0] rx_pat = '0;

  // behavioural reference: 0 idle, 1 sending, 2 receiving
  int m_mode = 0;
  int m_k = 0;
  logic [7:0] m_txb = '0, m_acc = '0, m_rxbuf = '0;
  logic m_ti = 1'b0, m_ri = 1'b0;

  always @(posedge clk) begin
    bit fin_tx, fin_rx;
    fin_tx = 1'b0;
    fin_rx = 1'b0;
    if (!rst_n) begin
      m_mode = 0; m_k = 0; m_txb = '0; m_acc = '0; m_rxbuf = '0;
      m_ti = 1'b0; m_ri = 1'b0;
    end else begin
      if (m_mode == 0) begin
        if (wr_valid) begin m_mode = 1; m_k = 0; m_txb = wr_data; end
        else if (clr_ri && rx_en) begin m_mode = 2; m_k = 0; end
      end else if (osc_en) begin
        if (m_mode == 2 && (m_k % BT) == LT - 1) m_acc[m_k / BT] = sd_in;
        if (m_k == NB * BT - 1) begin
          if (m_mode == 1) fin_tx = 1'b1; else fin_rx = 1'b1;
          m_mode = 0; m_k = 0;
        end else begin
          m_k++;
        end
      end
      if (clr_ti) m_ti = 1'b0;
      if (clr_ri) m_ri = 1'b0;
      if (fin_tx) m_ti = 1'b1;
      if (fin_rx) begin m_ri = 1'b1; m_rxbuf = m_acc; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, then drive peer data and the oscillator enable
  always @(negedge clk) begin
    logic e_sclk, e_out;
    cyc++;
    if (rst_n) begin
      e_sclk = !(m_mode != 0 && (m_k % BT) < LT);
      e_out  = (m_mode == 1) ? m_txb[m_k / BT] : 1'b1;
      check(sclk == e_sclk, "R1 sclk", sclk, e_sclk);
      check(sd_out == e_out, "R2 sd_out", sd_out, e_out);
      check(wr_ready == (m_mode == 0), "R3 wr_ready", wr_ready, m_mode == 0);
      check(ti == m_ti, "R4 ti", ti, m_ti);
      check(ri == m_ri, "R6 ri", ri, m_ri);
      check(rx_data == m_rxbuf, "R6 rx_data", rx_data, m_rxbuf);
      check(sd_oe == (m_mode == 1), "R9 sd_oe", sd_oe, m_mode == 1);
    end
    sd_in = (m_mode == 2) ? rx_pat[m_k / BT] : 1'b1;
    ocnt++;
    osc_en = (div == 0) ? 1'b0 : ((ocnt % div) == 0);
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tx_frame(input logic [7:0] d, input bit poke);
    int n;
    logic [7:0] got;
    int nb;
    logic prev;
    @(negedge clk);
    wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = '0;
    n = 0; nb = 0; got = '0; prev = sclk;
    while (!ti) begin
      @(negedge clk);
      n++;
      if (sclk && !prev && nb < NB) begin got[nb] = sd_out; nb++; end
      prev = sclk;
      if (div == 1) begin
        if (n == 9)  check(sclk == 1'b0, "R1 low at tick 9", sclk, 0);
        if (n == 10) check(sclk == 1'b1, "R1 high at tick 10", sclk, 1);
        if (n == 12) check(sclk == 1'b0, "R1 low at tick 12", sclk, 0);
      end
      if (poke && n == 30) begin
        check(wr_ready == 1'b0, "R3 busy mid-frame", wr_ready, 0);
        wr_data = 8'hFF; wr_valid = 1'b1;
      end
      if (poke && n == 31) begin wr_valid = 1'b0; wr_data = '0; end
    end
    check(got == d, "R2 lsb-first bits", got, d);
    if (div == 1) check(n == NB * BT, "R4 frame length", n, NB * BT);
    else check(n >= NB * BT * div - div && n <= NB * BT * div + div,
               "R8 slowed frame length", n, NB * BT * div);
    @(negedge clk);
    check(wr_ready && sclk, "R3 no second frame", {wr_ready, sclk}, 3);
    clr_ti = 1'b1;
    @(negedge clk);
    clr_ti = 1'b0;
    @(negedge clk);
    check(ti == 1'b0, "R4 ti cleared", ti, 0);
  endtask

  task automatic rx_frame(input logic [7:0] p);
    rx_pat = p;
    rx_en = 1'b1;
    @(negedge clk);
    clr_ri = 1'b1;
    @(negedge clk);
    clr_ri = 1'b0;
    check(sd_oe == 1'b0 && wr_ready == 1'b0, "R5 rx started", {sd_oe, wr_ready}, 0);
    while (!ri) @(negedge clk);
    check(rx_data == p, "R6 received byte", rx_data, p);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready == 1'b1, "R7 reset wr_ready", wr_ready, 1);
    check({ti, ri, sd_oe} == 3'b000, "R7 reset flags", {ti, ri, sd_oe}, 0);
    check(rx_data == 8'h00, "R7 reset rx_data", rx_data, 0);
    check(sclk && sd_out, "R7 idle lines", {sclk, sd_out}, 3);

    tx_frame(8'hA5, 1'b1);
    tx_frame(8'h01, 1'b0);
    tx_frame(8'h80, 1'b0);

    div = 3;
    tx_frame(8'h3C, 1'b0);
    div = 1;

    // R8: freeze mid-frame
    @(negedge clk);
    wr_data = 8'h5A; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (20) @(negedge clk);
    div = 0;
    @(negedge clk);
    begin
      logic s0, d0;
      s0 = sclk; d0 = sd_out;
      repeat (20) @(negedge clk);
      check(sclk == s0 && sd_out == d0, "R8 frozen without osc_en", {sclk, sd_out}, {s0, d0});
    end
    div = 1;
    while (!ti) @(negedge clk);
    clr_ti = 1'b1; @(negedge clk); clr_ti = 1'b0;

    rx_frame(8'h96);
    rx_frame(8'h01);
    rx_frame(8'h80);

    // R5: clear with receive disabled only clears the flag
    rx_en = 1'b0;
    @(negedge clk);
    clr_ri = 1'b1;
    @(negedge clk);
    clr_ri = 1'b0;
    repeat (20) @(negedge clk);
    check(wr_ready && sclk && !ri, "R5 no rx when disabled", {wr_ready, sclk, ri}, 6);

    // R9: write wins over receive start
    rx_en = 1'b1;
    @(negedge clk);
    wr_data = 8'hC3; wr_valid = 1'b1; clr_ri = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; clr_ri = 1'b0;
    check(sd_oe == 1'b1, "R9 tx wins", sd_oe, 1);
    while (!ti) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule